// File: doc/BRIEF.md
# Decimal Number String Recognizer

This block is a clocked recognizer that watches a stream of ASCII characters, one per clock cycle, qualified by a valid strobe. After each character it decides whether everything received since the last reset or clear forms a well-formed decimal real number. The accepted grammar has three parts. An optional minus sign may come first. One or more decimal digits must follow. An optional fraction part may close the string, and it is a dot followed by one or more digits.

The decision drives a single indicator output that is suitable for an LED. The indicator is high exactly when the string seen so far is accepted. A synchronous clear input starts a new string without a full reset. Internally the block is a six-state machine. Its states are start, after-sign, integer-digits, after-dot, fraction-digits and dead. Any character that has no legal transition sends the machine to the dead state, and it stays there until the next clear or reset.

Top module: `numstr_recognizer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the machine returns to its start state. After reset `accept_led` is low, because the empty string is not accepted.
- R2: On a cycle where `char_valid` is low and `clear` is low, the state does not change, so `accept_led` keeps its value whatever `char_byte` holds.
- R3: Digits are the bytes 0x30 to 0x39. A string made only of one or more digits is accepted. A byte just outside that range (0x2F or 0x3A) is not a digit.
- R4: The minus sign, byte 0x2D, is legal only as the first character. "-" alone is not accepted and "-7" is accepted. A minus at any later position, as in "5-" or "--3", sends the machine to the dead state.
- R5: The dot, byte 0x2E, is legal only right after at least one integer digit. ".5", "-.5" and "." are all rejected.
- R6: A string that ends in a dot is not accepted. A dot followed by one or more digits is accepted, for example "12.34" or "-0.5". A second dot, as in "1.2.3", sends the machine to the dead state.
- R7: Any other byte in any state sends the machine to the dead state. The dead state is absorbing: later digits never raise `accept_led` again before a clear or reset.
- R8: `clear` high at a clock edge returns the machine to the start state and drops `accept_led`. It takes priority over a valid character in the same cycle.
- R9: `accept_led` reflects the string including a character presented at a clock edge from just after that edge. It is high only in the integer-digits and fraction-digits states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Synchronous restart of the string, active high |
| char_valid | input | 1 | Qualifies `char_byte` for this cycle |
| char_byte | input | 8 | ASCII character code |
| accept_led | output | 1 | High when the string so far is a valid decimal number |

## Verification
Some behaviours are checked by the assertions on every cycle:
- The state holds when no character is strobed.
- Clear always restarts the string.
- The dead state is absorbing.
- Any byte outside the alphabet, and any minus sign after the first position, leads to the dead state.
- The indicator can only rise right after a valid digit.

Whole-string verdicts can only be shown by the bench's directed scenarios. These include signed and fractional numbers, a trailing dot, a leading dot, doubled signs or dots, recovery by clear, and bytes at the edges of the digit range.

// File: rtl/numstr_pkg.sv
// Package: shared types for the decimal number string recognizer.
// Assumes ASCII character codes on an 8-bit byte.
package numstr_pkg;

    // Recognizer state; the encoding is free, only the names matter.
    typedef enum logic [2:0] {
        ST_START = 3'd0,
        ST_SIGN  = 3'd1,
        ST_INT   = 3'd2,
        ST_DOT   = 3'd3,
        ST_FRAC  = 3'd4,
        ST_DEAD  = 3'd5
    } rec_state_t;

    // Class of an incoming character.
    typedef enum logic [1:0] {
        CC_DIGIT = 2'd0,
        CC_MINUS = 2'd1,
        CC_DOT   = 2'd2,
        CC_OTHER = 2'd3
    } char_class_t;

endpackage

// File: rtl/numstr_classify.sv
// Module: numstr_classify
// Sorts one character code into digit, minus, dot or other.
// Assumes the digit codes form one contiguous range [DIGIT_LO, DIGIT_HI].
module numstr_classify
    import numstr_pkg::*;
#(
    parameter int          CHAR_W   = 8,
    parameter logic [CHAR_W-1:0] DIGIT_LO = 8'h30,
    parameter logic [CHAR_W-1:0] DIGIT_HI = 8'h39,
    parameter logic [CHAR_W-1:0] MINUS_CH = 8'h2D,
    parameter logic [CHAR_W-1:0] DOT_CH   = 8'h2E
) (
    input  logic [CHAR_W-1:0] ch,
    output char_class_t       cls
);

    logic in_digit_range;

    // Range test for decimal digits.
    always_comb begin
        in_digit_range = (ch >= DIGIT_LO) && (ch <= DIGIT_HI);
    end

    // Class selection, digits first.
    always_comb begin
        if (in_digit_range)      cls = CC_DIGIT;
        else if (ch == MINUS_CH) cls = CC_MINUS;
        else if (ch == DOT_CH)   cls = CC_DOT;
        else                     cls = CC_OTHER;
    end

endmodule

// File: rtl/numstr_next.sv
// Module: numstr_next
// Next-state function of the recognizer for one classified character.
// Assumes the caller only applies the result on cycles with a valid character.
module numstr_next
    import numstr_pkg::*;
(
    input  rec_state_t  cur,
    input  char_class_t cls,
    output rec_state_t  nxt
);

    // Transition table; any unlisted pair goes to the dead state.
    always_comb begin
        nxt = ST_DEAD;
        unique case (cur)
            ST_START: begin
                if (cls == CC_MINUS)      nxt = ST_SIGN;
                else if (cls == CC_DIGIT) nxt = ST_INT;
            end
            ST_SIGN: begin
                if (cls == CC_DIGIT) nxt = ST_INT;
            end
            ST_INT: begin
                if (cls == CC_DIGIT)    nxt = ST_INT;
                else if (cls == CC_DOT) nxt = ST_DOT;
            end
            ST_DOT: begin
                if (cls == CC_DIGIT) nxt = ST_FRAC;
            end
            ST_FRAC: begin
                if (cls == CC_DIGIT) nxt = ST_FRAC;
            end
            default: nxt = ST_DEAD;
        endcase
    end

endmodule

// File: rtl/numstr_recognizer.sv
// Module: numstr_recognizer (top)
// Recognizes an optionally signed decimal number with an optional fraction
// part, one character per strobed cycle. accept_led is high while the string
// since the last reset or clear is valid. Assumes synchronous inputs.
module numstr_recognizer
    import numstr_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              char_valid,
    input  logic [CHAR_W-1:0] char_byte,
    output logic              accept_led
);

    rec_state_t  state_q;
    rec_state_t  state_nxt;
    char_class_t ch_cls;

    numstr_classify #(.CHAR_W(CHAR_W)) u_classify (
        .ch  (char_byte),
        .cls (ch_cls)
    );

    numstr_next u_next (
        .cur (state_q),
        .cls (ch_cls),
        .nxt (state_nxt)
    );

    // State register: reset and clear restart; a strobe advances.
    always_ff @(posedge clk) begin
        if (!rst_n)          state_q <= ST_START;
        else if (clear)      state_q <= ST_START;
        else if (char_valid) state_q <= state_nxt;
    end

    // Indicator decode: only the two digit-run states accept.
    always_comb begin
        accept_led = (state_q == ST_INT) || (state_q == ST_FRAC);
    end

endmodule

// File: rtl/numstr_recognizer_chk.sv
// Module: numstr_recognizer_chk
// Cycle-by-cycle properties of the recognizer, bound to the top module.
module numstr_recognizer_chk
    import numstr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       clear,
    input logic       char_valid,
    input logic [7:0] char_byte,
    input rec_state_t state_q,
    input logic       accept_led
);

    logic is_dig, is_alpha;

    // Independent character tests for the properties.
    always_comb begin
        is_dig   = (char_byte >= 8'h30) && (char_byte <= 8'h39);
        is_alpha = is_dig || (char_byte == 8'h2D) || (char_byte == 8'h2E);
    end

    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!char_valid && !clear) |=> $stable(state_q));

    a_r8_clear_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (state_q == ST_START) && !accept_led);

    a_r7_dead_absorbs: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEAD && !clear) |=> state_q == ST_DEAD);

    a_r7_other_kills: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && !clear && !is_alpha) |=> state_q == ST_DEAD);

    a_r4_late_minus: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && !clear && char_byte == 8'h2D && state_q != ST_START)
        |=> state_q == ST_DEAD);

    a_r9_rise_on_digit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(accept_led) |-> $past(char_valid && is_dig));

endmodule

bind numstr_recognizer numstr_recognizer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .char_valid (char_valid),
    .char_byte  (char_byte),
    .state_q    (state_q),
    .accept_led (accept_led)
);

// File: tb/numstr_recognizer_tb.sv
`timescale 1ns/1ps
// Directed bench for numstr_recognizer: one task per scenario.
module numstr_recognizer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear = 1'b0;
    logic       char_valid = 1'b0;
    logic [7:0] char_byte = 8'h00;
    logic       accept_led;
    int         total = 0;
    int         bad = 0;

    numstr_recognizer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .char_valid (char_valid),
        .char_byte  (char_byte),
        .accept_led (accept_led)
    );

    always #2.5 clk = ~clk;

    // Compare the indicator against the expected verdict.
    task automatic chk(input logic exp, input string tag);
        total++;
        if (accept_led !== exp) begin
            bad++;
            $display("FAIL %s: accept_led=%b expected=%b", tag, accept_led, exp);
        end
    endtask

    // Present one character for one edge; return at the following negedge.
    task automatic send(input logic [7:0] c);
        char_byte  = c;
        char_valid = 1'b1;
        @(negedge clk);
        char_valid = 1'b0;
    endtask

    // Restart with clear, feed a string, check the final verdict.
    task automatic feed(input string s, input logic exp, input string tag);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        for (int i = 0; i < s.len(); i++) send(s[i]);
        chk(exp, {tag, " \"", s, "\""});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(1'b0, "R1 empty after reset");
        send("4");
        chk(1'b1, "R1 first digit after reset");
    endtask

    task automatic t_digits();
        feed("0", 1'b1, "R3 single digit");
        feed("9876543210", 1'b1, "R3 digit run");
        feed("/", 1'b0, "R3 0x2F not digit");
        feed(":", 1'b0, "R3 0x3A not digit");
    endtask

    task automatic t_sign();
        feed("-", 1'b0, "R4 lone minus");
        feed("-7", 1'b1, "R4 signed");
        feed("5-", 1'b0, "R4 trailing minus");
        feed("--3", 1'b0, "R4 double minus");
    endtask

    task automatic t_dot();
        feed(".5", 1'b0, "R5 leading dot");
        feed("-.5", 1'b0, "R5 sign dot");
        feed(".", 1'b0, "R5 lone dot");
        feed("12.", 1'b0, "R6 trailing dot");
        feed("12.34", 1'b1, "R6 fraction");
        feed("-0.5", 1'b1, "R6 signed fraction");
        feed("1.2.3", 1'b0, "R6 second dot");
    endtask

    task automatic t_dead();
        feed("1a", 1'b0, "R7 letter");
        for (int i = 0; i < 4; i++) send("8");
        chk(1'b0, "R7 dead absorbs digits");
        feed(" 1", 1'b0, "R7 space first");
    endtask

    task automatic t_idle();
        feed("3", 1'b1, "R2 setup");
        char_byte = "x";
        repeat (3) @(negedge clk);
        chk(1'b1, "R2 idle ignores byte");
        send(".");
        chk(1'b0, "R9 after dot low");
        char_byte = "z";
        repeat (2) @(negedge clk);
        chk(1'b0, "R2 idle holds dot state");
        send("6");
        chk(1'b1, "R9 digit after dot");
    endtask

    task automatic t_clear();
        feed("42", 1'b1, "R8 setup");
        clear = 1'b1;
        char_byte = "5";
        char_valid = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        char_valid = 1'b0;
        chk(1'b0, "R8 clear beats valid");
        send("x");
        chk(1'b0, "R8 setup dead");
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        send("7");
        chk(1'b1, "R8 recovery from dead");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_digits();
        t_sign();
        t_dot();
        t_dead();
        t_idle();
        t_clear();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: timeout actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule